// File: doc/BRIEF.md
# Armed Position Registration Latch

This block is one channel of a registration capture unit. It watches a trigger that it picks from two encoder index pulses and two external digital inputs. When a software-style arm request has been given and a trigger edge that meets the configured edge and direction rules arrives, it stores the position count of one of two encoders. The capture is one-shot. An arm request opens the window. The first qualified event closes it, stores the position, and raises a found flag. A disarm request closes the window without a capture.

The external inputs are first synchronized through two flops. They then pass a stability filter whose length is set in steps of `STEP_CYCLES` clocks (10 cycles, or 100 ns at a 100 MHz clock). Index pulses are synchronized but not filtered. A second channel is made by instantiating the same module with `OWN_ENC` set to 1.

Top module: `regl_capture_chan`

## Requirements
- R1: With an external trigger source, `cfg_enc_sel` = 0 latches `enc0_pos` and `cfg_enc_sel` = 1 latches `enc1_pos`.
- R2: `cfg_src` selects the trigger as follows. 2'b10 uses `ext_trig_a`. 2'b01 uses `ext_trig_b`. 2'b11 uses the channel's own index pulse. 2'b00 uses the own index pulse ANDed with the filtered `ext_trig_a`. The unselected inputs cause no capture.
- R3: When `cfg_src` is 2'b00 or 2'b11, the channel's own encoder (`OWN_ENC`, default 0) is latched whatever the value of `cfg_enc_sel`. The index pulse of the other encoder is ignored.
- R4: `cfg_edge` works as follows. 2'b00 captures on a rising edge, 2'b01 on a falling edge, and 2'b10 on the first edge of either kind. 2'b11 blocks capture.
- R5: `cfg_dir` is checked against the selected encoder's `enc_fwd` bit, where 1 means forward. 2'b00 never captures. 2'b01 captures only in reverse, 2'b10 only forward, and 2'b11 in either direction.
- R6: With `cfg_filt` = N > 0, an external-input level that lasts fewer than N*`STEP_CYCLES` cycles is ignored, and a longer one is passed. N = 0 turns the filter off.
- R7: An arm request sets `armed` and clears `found` on the next clock.
- R8: A qualified edge while armed stores the position into `latch_pos`, sets `found` and clears `armed`, all on the clock after the edge becomes visible. This is the fourth clock after an external input changes with the filter off. `latch_pos` then holds through later triggers until the next capture.
- R9: A disarm request clears `armed`, and a later trigger then stores nothing.
- R10: A disarm request wins over an arm request in the same cycle. It also wins over a qualified edge in the same cycle: no capture occurs.
- R11: Reset clears `armed`, `found` and `latch_pos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc0_pos | input | POS_W | Position count of encoder 0 |
| enc1_pos | input | POS_W | Position count of encoder 1 |
| enc_fwd | input | 2 | Direction per encoder, 1 = forward |
| enc_idx | input | 2 | Index pulse per encoder |
| ext_trig_a | input | 1 | External trigger input A |
| ext_trig_b | input | 1 | External trigger input B |
| cfg_enc_sel | input | 1 | Encoder select for external sources |
| cfg_src | input | 2 | Trigger source code |
| cfg_edge | input | 2 | Edge code |
| cfg_dir | input | 2 | Direction qualifier code |
| cfg_filt | input | FILT_W | Filter length in steps |
| arm_req | input | 1 | Arm request pulse |
| disarm_req | input | 1 | Disarm request pulse |
| latch_pos | output | POS_W | Captured position |
| armed | output | 1 | Window open, waiting for a trigger |
| found | output | 1 | A capture has completed |

## Verification
A disarm request can land in the same cycle as a qualified trigger edge. Arm and disarm requests can also land together. The bench first measures the edge-to-capture latency in a control run. It then repeats that run with a one-cycle disarm placed exactly on the capture clock. The collision passes when `found` stays low, `armed` drops, and `latch_pos` keeps its earlier value. The arm/disarm collision is judged by `armed` being low on the next sample.

// File: rtl/regl_pkg.sv
package regl_pkg;
   typedef enum logic [1:0] {
      SRC_IDX_AND_A = 2'b00,
      SRC_EXT_B     = 2'b01,
      SRC_EXT_A     = 2'b10,
      SRC_IDX       = 2'b11
   } trig_src_e;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_OFF  = 2'b11
   } edge_sel_e;

   typedef enum logic [1:0] {
      DIR_NONE = 2'b00,
      DIR_REV  = 2'b01,
      DIR_FWD  = 2'b10,
      DIR_ANY  = 2'b11
   } dir_sel_e;
endpackage

// File: rtl/regl_sync.sv
module regl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("regl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/regl_glitch_filter.sv
module regl_glitch_filter #(
   parameter int CODE_W      = 4,
   parameter int STEP_CYCLES = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic              d,
   output logic              q
);
   localparam int MAX_LIM = ((1 << CODE_W) - 1) * STEP_CYCLES;
   localparam int CNT_W   = $clog2(MAX_LIM + 1);

   if (STEP_CYCLES < 1) begin : g_bad_step
      $error("regl_glitch_filter: STEP_CYCLES must be positive");
   end

   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] cnt;

   always_comb lim = CNT_W'(code) * CNT_W'(STEP_CYCLES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= 1'b0;
         cnt <= '0;
      end else if (code == '0) begin
         q   <= d;
         cnt <= '0;
      end else if (d == q) begin
         cnt <= '0;
      end else if (cnt >= lim - CNT_W'(1)) begin
         q   <= d;
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   // R6: the output only ever moves to the level the input held
   p_filt_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q) |-> (q == $past(d)));
endmodule

// File: rtl/regl_edge_qual.sv
module regl_edge_qual
   import regl_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      trig,
   input  edge_sel_e edge_sel,
   output logic      hit
);
   logic trig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= trig;
   end

   always_comb begin
      unique case (edge_sel)
         EDGE_RISE: hit = trig & ~trig_q;
         EDGE_FALL: hit = ~trig & trig_q;
         EDGE_BOTH: hit = trig ^ trig_q;
         default:   hit = 1'b0;
      endcase
   end

   // R4: a reported edge always matches a level change of the trigger
   p_hit_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (trig != trig_q));
endmodule

// File: rtl/regl_capture_chan.sv
module regl_capture_chan
   import regl_pkg::*;
#(
   parameter int POS_W       = 32,
   parameter int FILT_W      = 4,
   parameter int STEP_CYCLES = 10,
   parameter int SYNC_STAGES = 2,
   parameter int OWN_ENC     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [POS_W-1:0]  enc0_pos,
   input  logic [POS_W-1:0]  enc1_pos,
   input  logic [1:0]        enc_fwd,
   input  logic [1:0]        enc_idx,
   input  logic              ext_trig_a,
   input  logic              ext_trig_b,
   input  logic              cfg_enc_sel,
   input  logic [1:0]        cfg_src,
   input  logic [1:0]        cfg_edge,
   input  logic [1:0]        cfg_dir,
   input  logic [FILT_W-1:0] cfg_filt,
   input  logic              arm_req,
   input  logic              disarm_req,
   output logic [POS_W-1:0]  latch_pos,
   output logic              armed,
   output logic              found
);
   localparam int N_EXT = 2;
   localparam int N_ENC = 2;

   if (OWN_ENC < 0 || OWN_ENC >= N_ENC) begin : g_bad_own
      $error("regl_capture_chan: OWN_ENC must be 0 or 1");
   end
   if (POS_W < 1 || FILT_W < 1) begin : g_bad_width
      $error("regl_capture_chan: widths must be positive");
   end

   // external triggers: synchronize, then filter
   logic [N_EXT-1:0] ext_raw, ext_sync, ext_filt;
   assign ext_raw = {ext_trig_b, ext_trig_a};

   for (genvar i = 0; i < N_EXT; i++) begin : g_ext
      regl_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(ext_raw[i]), .q(ext_sync[i]));
      regl_glitch_filter #(.CODE_W(FILT_W), .STEP_CYCLES(STEP_CYCLES)) u_filt (
         .clk(clk), .rst_n(rst_n), .code(cfg_filt), .d(ext_sync[i]), .q(ext_filt[i]));
   end

   // index pulses: synchronize only
   logic [N_ENC-1:0] idx_sync;
   for (genvar e = 0; e < N_ENC; e++) begin : g_idx
      regl_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(enc_idx[e]), .q(idx_sync[e]));
   end

   logic own_idx;
   logic own_is_enc1;
   if (OWN_ENC == 1) begin : g_own1
      assign own_idx     = idx_sync[1];
      assign own_is_enc1 = 1'b1;
   end else begin : g_own0
      assign own_idx     = idx_sync[0];
      assign own_is_enc1 = 1'b0;
   end

   trig_src_e src;
   dir_sel_e  dsel;
   edge_sel_e esel;
   assign src  = trig_src_e'(cfg_src);
   assign dsel = dir_sel_e'(cfg_dir);
   assign esel = edge_sel_e'(cfg_edge);

   logic trig, idx_mode;
   always_comb begin
      unique case (src)
         SRC_IDX_AND_A: trig = own_idx & ext_filt[0];
         SRC_EXT_B:     trig = ext_filt[1];
         SRC_EXT_A:     trig = ext_filt[0];
         default:       trig = own_idx;
      endcase
      idx_mode = (src == SRC_IDX_AND_A) || (src == SRC_IDX);
   end

   logic edge_hit;
   regl_edge_qual u_edge (
      .clk(clk), .rst_n(rst_n), .trig(trig), .edge_sel(esel), .hit(edge_hit));

   logic             use_enc1, sel_fwd, dir_ok, qualified;
   logic [POS_W-1:0] sel_pos;
   always_comb begin
      use_enc1 = idx_mode ? own_is_enc1 : cfg_enc_sel;
      sel_pos  = use_enc1 ? enc1_pos   : enc0_pos;
      sel_fwd  = use_enc1 ? enc_fwd[1] : enc_fwd[0];
      unique case (dsel)
         DIR_NONE: dir_ok = 1'b0;
         DIR_REV:  dir_ok = ~sel_fwd;
         DIR_FWD:  dir_ok = sel_fwd;
         default:  dir_ok = 1'b1;
      endcase
      qualified = edge_hit & dir_ok;
   end

   // arm / found handshake; disarm has top priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         found     <= 1'b0;
         latch_pos <= '0;
      end else if (disarm_req) begin
         armed <= 1'b0;
      end else if (arm_req) begin
         armed <= 1'b1;
         found <= 1'b0;
      end else if (armed && qualified) begin
         armed     <= 1'b0;
         found     <= 1'b1;
         latch_pos <= sel_pos;
      end
   end

   p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_req && !disarm_req) |=> (armed && !found));

   p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      disarm_req |=> !armed);

   p_found_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(found) |-> (!armed && $past(armed)));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(latch_pos) |-> $rose(found));

   p_disarm_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      disarm_req |=> $stable(latch_pos));
endmodule

// File: tb/regl_capture_chan_tb.sv
`timescale 1ns/1ps
module regl_capture_chan_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] enc0_pos = '0, enc1_pos = '0;
   logic [1:0]  enc_fwd = 2'b11, enc_idx = 2'b00;
   logic        ext_trig_a = 1'b0, ext_trig_b = 1'b0;
   logic        cfg_enc_sel = 1'b0;
   logic [1:0]  cfg_src = 2'b10, cfg_edge = 2'b00, cfg_dir = 2'b11;
   logic [3:0]  cfg_filt = 4'd0;
   logic        arm_req = 1'b0, disarm_req = 1'b0;
   logic [31:0] latch_pos;
   logic        armed, found;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   regl_capture_chan u_dut (
      .clk(clk), .rst_n(rst_n), .enc0_pos(enc0_pos), .enc1_pos(enc1_pos),
      .enc_fwd(enc_fwd), .enc_idx(enc_idx), .ext_trig_a(ext_trig_a),
      .ext_trig_b(ext_trig_b), .cfg_enc_sel(cfg_enc_sel), .cfg_src(cfg_src),
      .cfg_edge(cfg_edge), .cfg_dir(cfg_dir), .cfg_filt(cfg_filt),
      .arm_req(arm_req), .disarm_req(disarm_req), .latch_pos(latch_pos),
      .armed(armed), .found(found));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_arm();
      @(negedge clk) arm_req = 1'b1;
      @(negedge clk) arm_req = 1'b0;
   endtask

   task automatic pulse_a(input int w);
      @(negedge clk) ext_trig_a = 1'b1;
      cyc(w);
      ext_trig_a = 1'b0;
      cyc(40);
   endtask

   task automatic pulse_b(input int w);
      @(negedge clk) ext_trig_b = 1'b1;
      cyc(w);
      ext_trig_b = 1'b0;
      cyc(40);
   endtask

   task automatic pulse_idx(input int e);
      @(negedge clk) enc_idx[e] = 1'b1;
      cyc(2);
      enc_idx[e] = 1'b0;
      cyc(10);
   endtask

   task automatic t_reset();
      chk("R11 armed", {31'd0, armed}, 32'd0);
      chk("R11 found", {31'd0, found}, 32'd0);
      chk("R11 latch", latch_pos, 32'd0);
   endtask

   task automatic t_enc_select();
      cfg_src = 2'b10; cfg_edge = 2'b00; cfg_dir = 2'b11;
      enc0_pos = 32'h0000_0111; enc1_pos = 32'h0000_0222;
      cfg_enc_sel = 1'b0;
      do_arm();
      chk("R7 armed after arm", {31'd0, armed}, 32'd1);
      pulse_a(5);
      chk("R1 enc0 latched", latch_pos, 32'h111);
      chk("R8 found set", {31'd0, found}, 32'd1);
      chk("R8 armed cleared", {31'd0, armed}, 32'd0);
      cfg_enc_sel = 1'b1;
      do_arm();
      chk("R7 found cleared by arm", {31'd0, found}, 32'd0);
      pulse_a(5);
      chk("R1 enc1 latched", latch_pos, 32'h222);
   endtask

   task automatic t_one_shot();
      enc1_pos = 32'h0000_0999;
      pulse_a(5);
      chk("R8 held after later trigger", latch_pos, 32'h222);
      chk("R8 found stays", {31'd0, found}, 32'd1);
   endtask

   task automatic t_src_b();
      cfg_src = 2'b01; cfg_enc_sel = 1'b0; enc0_pos = 32'h0000_0b0b;
      do_arm();
      pulse_a(5);
      chk("R2 ext A ignored with src B", {31'd0, found}, 32'd0);
      pulse_b(5);
      chk("R2 ext B captures", latch_pos, 32'hb0b);
   endtask

   task automatic t_index();
      cfg_src = 2'b11; cfg_enc_sel = 1'b1;
      enc0_pos = 32'h0000_1d00; enc1_pos = 32'h0000_1d11;
      do_arm();
      pulse_idx(1);
      chk("R3 other index ignored", {31'd0, found}, 32'd0);
      pulse_idx(0);
      chk("R3 own encoder latched", latch_pos, 32'h1d00);
   endtask

   task automatic t_and_mode();
      cfg_src = 2'b00; enc0_pos = 32'h0000_a0d0;
      do_arm();
      pulse_idx(0);
      chk("R2 index alone ignored in AND mode", {31'd0, found}, 32'd0);
      pulse_a(5);
      chk("R2 ext A alone ignored in AND mode", {31'd0, found}, 32'd0);
      @(negedge clk) ext_trig_a = 1'b1;
      cyc(10);
      pulse_idx(0);
      chk("R2 index AND ext A captures", latch_pos, 32'ha0d0);
      ext_trig_a = 1'b0;
      cyc(10);
   endtask

   task automatic edge_run(input logic [1:0] code, input logic [31:0] exp,
                           input logic exp_found, input string req);
      cfg_src = 2'b10; cfg_enc_sel = 1'b0; cfg_edge = code;
      do_arm();
      enc0_pos = 32'h0000_e001;
      @(negedge clk) ext_trig_a = 1'b1;
      cyc(15);
      enc0_pos = 32'h0000_e002;
      cyc(5);
      ext_trig_a = 1'b0;
      cyc(15);
      chk(req, {31'd0, found}, {31'd0, exp_found});
      if (exp_found) chk(req, latch_pos, exp);
   endtask

   task automatic t_edges();
      edge_run(2'b00, 32'he001, 1'b1, "R4 rising");
      edge_run(2'b01, 32'he002, 1'b1, "R4 falling");
      edge_run(2'b10, 32'he001, 1'b1, "R4 both first edge");
      edge_run(2'b11, 32'h0,    1'b0, "R4 disabled");
      @(negedge clk) disarm_req = 1'b1;
      @(negedge clk) disarm_req = 1'b0;
      cfg_edge = 2'b00;
   endtask

   task automatic t_dir();
      cfg_src = 2'b10; cfg_enc_sel = 1'b0; enc0_pos = 32'h0000_d111;
      cfg_dir = 2'b10; enc_fwd = 2'b10;
      do_arm();
      pulse_a(5);
      chk("R5 forward-only blocks reverse", {31'd0, found}, 32'd0);
      cfg_dir = 2'b00; enc_fwd = 2'b01;
      pulse_a(5);
      chk("R5 not configured blocks", {31'd0, found}, 32'd0);
      cfg_dir = 2'b10;
      pulse_a(5);
      chk("R5 forward captures", latch_pos, 32'hd111);
      cfg_dir = 2'b01; enc_fwd = 2'b10; enc0_pos = 32'h0000_d222;
      do_arm();
      pulse_a(5);
      chk("R5 reverse captures", latch_pos, 32'hd222);
      cfg_dir = 2'b11; enc_fwd = 2'b11;
   endtask

   task automatic t_filter();
      cfg_src = 2'b10; cfg_filt = 4'd2; enc0_pos = 32'h0000_f17e;
      do_arm();
      pulse_a(15);
      chk("R6 short pulse ignored", {31'd0, found}, 32'd0);
      chk("R6 still armed", {31'd0, armed}, 32'd1);
      pulse_a(30);
      chk("R6 long pulse passes", latch_pos, 32'hf17e);
      cfg_filt = 4'd0;
      cyc(5);
   endtask

   task automatic t_disarm();
      enc0_pos = 32'h0000_5555;
      do_arm();
      @(negedge clk) disarm_req = 1'b1;
      @(negedge clk) disarm_req = 1'b0;
      chk("R9 armed cleared", {31'd0, armed}, 32'd0);
      pulse_a(5);
      chk("R9 no capture after disarm", {31'd0, found}, 32'd0);
      chk("R9 latch unchanged", latch_pos, 32'hf17e);
   endtask

   task automatic t_collide();
      // control run: measure latency with filter off
      enc0_pos = 32'h0000_c0c0;
      do_arm();
      @(negedge clk) ext_trig_a = 1'b1;
      cyc(3);
      chk("R8 not yet captured", {31'd0, found}, 32'd0);
      cyc(1);
      chk("R8 capture on fourth clock", {31'd0, found}, 32'd1);
      ext_trig_a = 1'b0;
      cyc(10);
      // disarm lands on the capture clock
      enc0_pos = 32'h0000_dead;
      do_arm();
      @(negedge clk) ext_trig_a = 1'b1;
      cyc(3);
      disarm_req = 1'b1;
      @(negedge clk) disarm_req = 1'b0;
      chk("R10 disarm beats edge found", {31'd0, found}, 32'd0);
      chk("R10 disarm beats edge armed", {31'd0, armed}, 32'd0);
      chk("R10 disarm beats edge latch", latch_pos, 32'hc0c0);
      ext_trig_a = 1'b0;
      cyc(10);
      @(negedge clk) begin arm_req = 1'b1; disarm_req = 1'b1; end
      @(negedge clk) begin arm_req = 1'b0; disarm_req = 1'b0; end
      chk("R10 disarm beats arm", {31'd0, armed}, 32'd0);
   endtask

   initial begin
      fork
         begin
            cyc(3);
            t_reset();
            @(negedge clk) rst_n = 1'b1;
            cyc(2);
            t_reset();
            t_enc_select();
            t_one_shot();
            t_src_b();
            t_index();
            t_and_mode();
            t_edges();
            t_dir();
            t_filter();
            t_disarm();
            t_collide();
         end
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule